// File: doc/BRIEF.md
# Byte-Oriented File Register ALU

This block is the execute stage for the byte-wide register-file instructions of a small 8-bit accumulator core. Each issued instruction arrives as a 16-bit word together with the byte read from the addressed file register, the working register W and the current status flags. The block decodes the opcode and computes the 8-bit result. It returns that result with one write enable, either for W or for the file register. It also returns the new status flags, where each opcode updates only the flags it owns.

The operations covered are add, add with carry, three forms of subtraction, increment, decrement, negate, AND, OR, XOR, complement, move, rotates with and without carry, nibble swap, clear, set and move-W-to-file. Fetch, bank addressing, skip handling, multiplication and peripheral side effects belong to other blocks. Results are registered, so the outputs for an instruction issued on one rising edge are valid until the next edge, for exactly one cycle.

Top module: `regFileAlu`

## Requirements
- R1: While reset (active low) is asserted, resValid, wregWrEn and fileWrEn are 0, and result and flagsOut are 0.
- R2: An instruction sampled with issueValid high on a rising edge produces resValid high for exactly one cycle after that edge. With issueValid low, no write enable is raised.
- R3: For opcodes that carry a destination bit (bit 9 of the word), 0 selects W (wregWrEn) and 1 selects the file register (fileWrEn). Negate, clear, set and move-W-to-file (bits 15:9 = 0110110, 0110101, 0110100, 0110111) always write the file register. Never are both enables high.
- R4: Add (bits 15:10 = 001001), add with carry (001000) and increment (001010) produce f+W, f+W+C and f+1. They update C (carry out of bit 7), DC (carry out of bit 3), Z, OV and N.
- R5: Subtract W from f (010111) gives f−W. The borrow form (010110) gives f−W−(1−C). Subtract f from W with borrow (010101) gives W−f−(1−C). Decrement (000001) gives f−1 and negate gives 0−f. All of these update all five flags, with C and DC each set to 1 when no borrow occurs out of bit 7 and bit 3 respectively.
- R6: AND (000101), OR (000100), XOR (000110), complement (000111) and move f (010100) update only Z and N.
- R7: Rotate left and right through carry (001101, 001100) move the bit leaving the byte into C and C into the vacated bit, and update C, Z and N. Rotate left and right without carry (010001, 010000) wrap the bit around and update only Z and N.
- R8: Nibble swap (001110) exchanges bits 7:4 and 3:0 and keeps all flags. Set writes 0xFF and keeps all flags. Move-W-to-file writes W and keeps all flags. Clear writes 0x00 and updates only Z, which becomes 1.
- R9: Any other opcode raises no write enable, and flagsOut equals the flags presented with it.
- R10: The flag vector is laid out as C=bit0, DC=bit1, Z=bit2, OV=bit3, N=bit4. Z is 1 when the 8-bit result is zero, N copies result bit 7, and OV flags signed two's-complement overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | Instruction and operands valid this cycle |
| instrWord | input | 16 | Instruction word |
| fileOperand | input | 8 | Byte read from the addressed file register |
| wregIn | input | 8 | Current working register |
| flagsIn | input | 5 | Current status flags {N,OV,Z,DC,C} |
| resValid | output | 1 | Registered result valid |
| result | output | 8 | Computed byte |
| wregWrEn | output | 1 | Write result to W |
| fileWrEn | output | 1 | Write result to the file register |
| flagsOut | output | 5 | Next status flags {N,OV,Z,DC,C} |

## Verification
A wrong decode or a wrong operand-select inside the block shows up one cycle after issue, on the same cycle's result, enable or flag bits, because nothing is carried from one instruction to the next. A flag mask that is too wide shows as a flag moving that should have held its input value. A mask that is too narrow shows as a stale flag. A wrong carry-in or an inverted subtract operand changes C, DC or OV first, so carry, borrow and overflow edge values are aimed at directly, alongside a long stream of random instructions compared every cycle.

// File: rtl/regFileAluPkg.sv
package regFileAluPkg;
  localparam int FLAG_W = 5;
  localparam int FLG_C  = 0;
  localparam int FLG_DC = 1;
  localparam int FLG_Z  = 2;
  localparam int FLG_OV = 3;
  localparam int FLG_N  = 4;

  typedef enum logic [4:0] {
    OP_NONE, OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOV,
    OP_ADD, OP_ADDC, OP_INC, OP_SUB, OP_SUBB, OP_SUBFB, OP_DEC, OP_NEG,
    OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SWAP, OP_CLR, OP_SET, OP_MOVW
  } aluOpE;

  typedef struct packed {
    aluOpE              op;
    logic [FLAG_W-1:0]  flagMask;
    logic               toW;
    logic               toFile;
    logic               legal;
  } aluCtrlT;
endpackage

// File: rtl/regFileAluCtrl.sv
module regFileAluCtrl
  import regFileAluPkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic [INSTR_W-1:0] instrWord,
  output aluCtrlT            ctrl
);
  localparam int DEST_BIT = INSTR_W - 7;
  localparam logic [FLAG_W-1:0] M_ALL  = 5'b11111;
  localparam logic [FLAG_W-1:0] M_ZN   = 5'b10100;
  localparam logic [FLAG_W-1:0] M_CZN  = 5'b10101;
  localparam logic [FLAG_W-1:0] M_Z    = 5'b00100;
  localparam logic [FLAG_W-1:0] M_NONE = 5'b00000;

  logic [5:0] top6;
  logic [6:0] top7;
  logic       destBit;
  logic       hasDest;

  assign top6    = instrWord[INSTR_W-1 -: 6];
  assign top7    = instrWord[INSTR_W-1 -: 7];
  assign destBit = instrWord[DEST_BIT];

  always_comb begin
    ctrl.op       = OP_NONE;
    ctrl.flagMask = M_NONE;
    hasDest       = 1'b1;
    unique case (top6)
      6'b000101: begin ctrl.op = OP_AND;   ctrl.flagMask = M_ZN;  end
      6'b000100: begin ctrl.op = OP_IOR;   ctrl.flagMask = M_ZN;  end
      6'b000110: begin ctrl.op = OP_XOR;   ctrl.flagMask = M_ZN;  end
      6'b000111: begin ctrl.op = OP_COM;   ctrl.flagMask = M_ZN;  end
      6'b010100: begin ctrl.op = OP_MOV;   ctrl.flagMask = M_ZN;  end
      6'b001001: begin ctrl.op = OP_ADD;   ctrl.flagMask = M_ALL; end
      6'b001000: begin ctrl.op = OP_ADDC;  ctrl.flagMask = M_ALL; end
      6'b001010: begin ctrl.op = OP_INC;   ctrl.flagMask = M_ALL; end
      6'b010111: begin ctrl.op = OP_SUB;   ctrl.flagMask = M_ALL; end
      6'b010110: begin ctrl.op = OP_SUBB;  ctrl.flagMask = M_ALL; end
      6'b010101: begin ctrl.op = OP_SUBFB; ctrl.flagMask = M_ALL; end
      6'b000001: begin ctrl.op = OP_DEC;   ctrl.flagMask = M_ALL; end
      6'b001101: begin ctrl.op = OP_RLC;   ctrl.flagMask = M_CZN; end
      6'b001100: begin ctrl.op = OP_RRC;   ctrl.flagMask = M_CZN; end
      6'b010001: begin ctrl.op = OP_RL;    ctrl.flagMask = M_ZN;  end
      6'b010000: begin ctrl.op = OP_RR;    ctrl.flagMask = M_ZN;  end
      6'b001110: begin ctrl.op = OP_SWAP;  ctrl.flagMask = M_NONE; end
      default: begin
        hasDest = 1'b0;
        unique case (top7)
          7'b0110110: begin ctrl.op = OP_NEG;  ctrl.flagMask = M_ALL;  end
          7'b0110101: begin ctrl.op = OP_CLR;  ctrl.flagMask = M_Z;    end
          7'b0110100: begin ctrl.op = OP_SET;  ctrl.flagMask = M_NONE; end
          7'b0110111: begin ctrl.op = OP_MOVW; ctrl.flagMask = M_NONE; end
          default:    begin ctrl.op = OP_NONE; ctrl.flagMask = M_NONE; end
        endcase
      end
    endcase
    ctrl.legal  = (ctrl.op != OP_NONE);
    ctrl.toW    = ctrl.legal && hasDest && !destBit;
    ctrl.toFile = ctrl.legal && (!hasDest || destBit);
  end
endmodule

// File: rtl/regFileAluPath.sv
module regFileAluPath
  import regFileAluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluCtrlT            ctrl,
  input  logic [DATA_W-1:0]  fileOperand,
  input  logic [DATA_W-1:0]  wregIn,
  input  logic [FLAG_W-1:0]  flagsIn,
  output logic [DATA_W-1:0]  resultNext,
  output logic [FLAG_W-1:0]  flagsNext
);
  localparam int NIB = DATA_W / 2;
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] addA, addB, plainRes, resVal;
  logic              addCin, useAdd, rotC;
  logic [DATA_W:0]   fullSum;
  logic [NIB:0]      lowSum;
  logic [FLAG_W-1:0] candFlags;
  logic              carryIn;

  assign carryIn = flagsIn[FLG_C];

  always_comb begin
    addA     = '0;
    addB     = '0;
    addCin   = 1'b0;
    useAdd   = 1'b0;
    plainRes = '0;
    rotC     = carryIn;
    unique case (ctrl.op)
      OP_ADD:   begin useAdd = 1'b1; addA = fileOperand; addB = wregIn; end
      OP_ADDC:  begin useAdd = 1'b1; addA = fileOperand; addB = wregIn; addCin = carryIn; end
      OP_INC:   begin useAdd = 1'b1; addA = fileOperand; addCin = 1'b1; end
      OP_SUB:   begin useAdd = 1'b1; addA = fileOperand; addB = ~wregIn; addCin = 1'b1; end
      OP_SUBB:  begin useAdd = 1'b1; addA = fileOperand; addB = ~wregIn; addCin = carryIn; end
      OP_SUBFB: begin useAdd = 1'b1; addA = wregIn; addB = ~fileOperand; addCin = carryIn; end
      OP_DEC:   begin useAdd = 1'b1; addA = fileOperand; addB = '1; end
      OP_NEG:   begin useAdd = 1'b1; addB = ~fileOperand; addCin = 1'b1; end
      OP_AND:   plainRes = fileOperand & wregIn;
      OP_IOR:   plainRes = fileOperand | wregIn;
      OP_XOR:   plainRes = fileOperand ^ wregIn;
      OP_COM:   plainRes = ~fileOperand;
      OP_MOV:   plainRes = fileOperand;
      OP_RLC:   begin plainRes = {fileOperand[MSB-1:0], carryIn}; rotC = fileOperand[MSB]; end
      OP_RRC:   begin plainRes = {carryIn, fileOperand[MSB:1]};   rotC = fileOperand[0];   end
      OP_RL:    plainRes = {fileOperand[MSB-1:0], fileOperand[MSB]};
      OP_RR:    plainRes = {fileOperand[0], fileOperand[MSB:1]};
      OP_SWAP:  plainRes = {fileOperand[NIB-1:0], fileOperand[MSB:NIB]};
      OP_CLR:   plainRes = '0;
      OP_SET:   plainRes = '1;
      OP_MOVW:  plainRes = wregIn;
      default:  plainRes = '0;
    endcase
  end

  assign fullSum = {1'b0, addA} + {1'b0, addB} + {{DATA_W{1'b0}}, addCin};
  assign lowSum  = {1'b0, addA[NIB-1:0]} + {1'b0, addB[NIB-1:0]} + {{NIB{1'b0}}, addCin};
  assign resVal  = useAdd ? fullSum[DATA_W-1:0] : plainRes;

  always_comb begin
    candFlags         = '0;
    candFlags[FLG_C]  = useAdd ? fullSum[DATA_W] : rotC;
    candFlags[FLG_DC] = lowSum[NIB];
    candFlags[FLG_Z]  = (resVal == '0);
    candFlags[FLG_OV] = (addA[MSB] == addB[MSB]) && (resVal[MSB] != addA[MSB]);
    candFlags[FLG_N]  = resVal[MSB];
  end

  assign flagsNext  = (candFlags & ctrl.flagMask) | (flagsIn & ~ctrl.flagMask);
  assign resultNext = resVal;
endmodule

// File: rtl/regFileAlu.sv
module regFileAlu
  import regFileAluPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [DATA_W-1:0]  fileOperand,
  input  logic [DATA_W-1:0]  wregIn,
  input  logic [FLAG_W-1:0]  flagsIn,
  output logic               resValid,
  output logic [DATA_W-1:0]  result,
  output logic               wregWrEn,
  output logic               fileWrEn,
  output logic [FLAG_W-1:0]  flagsOut
);
  aluCtrlT           ctrl;
  logic [DATA_W-1:0] resultNext;
  logic [FLAG_W-1:0] flagsNext;

  regFileAluCtrl #(.INSTR_W(INSTR_W)) ctrl_i (
    .instrWord (instrWord),
    .ctrl      (ctrl)
  );

  regFileAluPath #(.DATA_W(DATA_W)) path_i (
    .ctrl        (ctrl),
    .fileOperand (fileOperand),
    .wregIn      (wregIn),
    .flagsIn     (flagsIn),
    .resultNext  (resultNext),
    .flagsNext   (flagsNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      wregWrEn <= 1'b0;
      fileWrEn <= 1'b0;
      result   <= '0;
      flagsOut <= '0;
    end else begin
      resValid <= issueValid;
      wregWrEn <= issueValid && ctrl.toW;
      fileWrEn <= issueValid && ctrl.toFile;
      if (issueValid) begin
        result   <= resultNext;
        flagsOut <= flagsNext;
      end
    end
  end

  // R3: one destination at most
  a_r3_single_dest: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wregWrEn, fileWrEn}));

  // R2: no write without an issued instruction
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (!wregWrEn && !fileWrEn));

  // R9: undecoded opcode writes nothing and passes flags through
  a_r9_illegal_inert: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !ctrl.legal) |=> (!wregWrEn && !fileWrEn && flagsOut == $past(flagsIn)));

  // R10: Z tracks a zero result when the opcode owns Z
  a_r10_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && ctrl.flagMask[FLG_Z]) |=> (flagsOut[FLG_Z] == (result == '0)));

  // R10: N copies the result sign when the opcode owns N
  a_r10_neg_flag: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && ctrl.flagMask[FLG_N]) |=> (flagsOut[FLG_N] == result[DATA_W-1]));

  // R6: flags outside the opcode's set keep their input value
  a_r6_unowned_hold: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> (((flagsOut ^ $past(flagsIn)) & ~$past(ctrl.flagMask)) == '0));
endmodule

// File: tb/regFileAlu_tb.sv
module regFileAlu_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        issueValid;
  logic [15:0] instrWord;
  logic [7:0]  fileOperand, wregIn;
  logic [4:0]  flagsIn;
  logic        resValid, wregWrEn, fileWrEn;
  logic [7:0]  result;
  logic [4:0]  flagsOut;

  int checks = 0;
  int errors = 0;

  bit         pend = 0;
  bit         pendIssue;
  int         expRes;
  bit         expW, expF;
  logic [4:0] expFl;
  string      expTag;

  always #5 clk = ~clk;

  regFileAlu dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instrWord(instrWord),
    .fileOperand(fileOperand), .wregIn(wregIn), .flagsIn(flagsIn),
    .resValid(resValid), .result(result), .wregWrEn(wregWrEn),
    .fileWrEn(fileWrEn), .flagsOut(flagsOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // behavioural reference
  function automatic void refModel(input logic [15:0] iw, input int f, input int w,
      input logic [4:0] fl, output int res, output bit toW, output bit toF,
      output logic [4:0] flOut, output string tag);
    int c, r, s, lo;
    bit hasD, legal, mc, mdc, mz, mov, mn;
    bit nc, ndc, nov;
    c = fl[0]; res = 0; hasD = 1; legal = 1; tag = "R9";
    mc = 0; mdc = 0; mz = 0; mov = 0; mn = 0; nc = 0; ndc = 0; nov = 0;
    case (iw[15:10])
      6'b001001, 6'b001000, 6'b001010: begin
        int b, ci;
        tag = "R4";
        b  = (iw[15:10] == 6'b001010) ? 0 : w;
        ci = (iw[15:10] == 6'b001000) ? c : ((iw[15:10] == 6'b001010) ? 1 : 0);
        r = f + b + ci; lo = (f % 16) + (b % 16) + ci; s = sx(f) + sx(b) + ci;
        res = r % 256; nc = r > 255; ndc = lo > 15; nov = (s > 127) || (s < -128);
        {mc, mdc, mz, mov, mn} = 5'b11111;
      end
      6'b010111, 6'b010110, 6'b010101, 6'b000001: begin
        int a, b, bor;
        tag = "R5";
        case (iw[15:10])
          6'b010111: begin a = f; b = w; bor = 0; end
          6'b010110: begin a = f; b = w; bor = 1 - c; end
          6'b010101: begin a = w; b = f; bor = 1 - c; end
          default:   begin a = f; b = 1; bor = 0; end
        endcase
        r = a - b - bor; lo = (a % 16) - (b % 16) - bor; s = sx(a) - sx(b) - bor;
        res = (r + 512) % 256; nc = r >= 0; ndc = lo >= 0; nov = (s > 127) || (s < -128);
        {mc, mdc, mz, mov, mn} = 5'b11111;
      end
      6'b000101: begin tag = "R6"; res = f & w; mz = 1; mn = 1; end
      6'b000100: begin tag = "R6"; res = f | w; mz = 1; mn = 1; end
      6'b000110: begin tag = "R6"; res = f ^ w; mz = 1; mn = 1; end
      6'b000111: begin tag = "R6"; res = 255 - f; mz = 1; mn = 1; end
      6'b010100: begin tag = "R6"; res = f; mz = 1; mn = 1; end
      6'b001101: begin tag = "R7"; res = (f * 2) % 256 + c; nc = f >= 128; mc = 1; mz = 1; mn = 1; end
      6'b001100: begin tag = "R7"; res = f / 2 + c * 128; nc = f % 2; mc = 1; mz = 1; mn = 1; end
      6'b010001: begin tag = "R7"; res = (f * 2) % 256 + f / 128; mz = 1; mn = 1; end
      6'b010000: begin tag = "R7"; res = f / 2 + (f % 2) * 128; mz = 1; mn = 1; end
      6'b001110: begin tag = "R8"; res = (f % 16) * 16 + f / 16; end
      default: begin
        hasD = 0;
        case (iw[15:9])
          7'b0110110: begin
            tag = "R5"; r = 0 - f; lo = 0 - (f % 16); s = 0 - sx(f);
            res = (r + 256) % 256; nc = r >= 0; ndc = lo >= 0; nov = s > 127;
            {mc, mdc, mz, mov, mn} = 5'b11111;
          end
          7'b0110101: begin tag = "R8"; res = 0; mz = 1; end
          7'b0110100: begin tag = "R8"; res = 255; end
          7'b0110111: begin tag = "R8"; res = w; end
          default: legal = 0;
        endcase
      end
    endcase
    flOut = fl;
    if (legal) begin
      if (mc)  flOut[0] = nc;
      if (mdc) flOut[1] = ndc;
      if (mz)  flOut[2] = (res == 0);
      if (mov) flOut[3] = nov;
      if (mn)  flOut[4] = res >= 128;
    end
    toW = legal && hasD && !iw[9];
    toF = legal && (!hasD || iw[9]);
  endfunction

  task automatic checkPending();
    if (!pend) return;
    if (pendIssue) begin
      chk("R2", "resValid", resValid, 1);
      chk(expTag, "result", result, expRes);
      chk("R3", "wregWrEn", wregWrEn, expW);
      chk("R3", "fileWrEn", fileWrEn, expF);
      chk({expTag, "/R10"}, "flags", flagsOut, expFl);
    end else begin
      chk("R2", "idle resValid", resValid, 0);
      chk("R2", "idle wregWrEn", wregWrEn, 0);
      chk("R2", "idle fileWrEn", fileWrEn, 0);
    end
  endtask

  task automatic issue(input logic [15:0] iw, input logic [7:0] f, input logic [7:0] w,
      input logic [4:0] fl);
    @(negedge clk);
    checkPending();
    issueValid = 1; instrWord = iw; fileOperand = f; wregIn = w; flagsIn = fl;
    refModel(iw, int'(f), int'(w), fl, expRes, expW, expF, expFl, expTag);
    pend = 1; pendIssue = 1;
  endtask

  task automatic idle();
    @(negedge clk);
    checkPending();
    issueValid = 0; instrWord = $urandom; fileOperand = $urandom;
    pend = 1; pendIssue = 0;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] p6 [17];
    logic [6:0] p7 [4];
    p6 = '{6'b000101, 6'b000100, 6'b000110, 6'b000111, 6'b010100, 6'b001001,
           6'b001000, 6'b001010, 6'b010111, 6'b010110, 6'b010101, 6'b000001,
           6'b001101, 6'b001100, 6'b010001, 6'b010000, 6'b001110};
    p7 = '{7'b0110110, 7'b0110101, 7'b0110100, 7'b0110111};
    rstN = 0; issueValid = 1; instrWord = 16'h2401; fileOperand = 8'h55;
    wregIn = 8'hAA; flagsIn = 5'h1F;
    repeat (3) @(negedge clk);
    // R1: reset values even with an instruction presented
    chk("R1", "resValid", resValid, 0);
    chk("R1", "wregWrEn", wregWrEn, 0);
    chk("R1", "fileWrEn", fileWrEn, 0);
    chk("R1", "result", result, 0);
    chk("R1", "flagsOut", flagsOut, 0);
    issueValid = 0;
    rstN = 1;
    // R4 directed: overflow, carry, carry-in
    issue(16'h2610, 8'h7F, 8'h01, 5'h00);
    issue(16'h2410, 8'hFF, 8'h01, 5'h00);
    issue(16'h2210, 8'h0F, 8'h00, 5'h01);
    issue(16'h2A10, 8'hFF, 8'h00, 5'h00);
    // R5 directed: all subtract forms and edge values
    issue(16'h5E10, 8'h03, 8'h05, 5'h00);
    issue(16'h5C10, 8'h42, 8'h42, 5'h00);
    issue(16'h5A10, 8'h80, 8'h01, 5'h00);
    issue(16'h5810, 8'h10, 8'h01, 5'h01);
    issue(16'h5610, 8'h01, 8'h00, 5'h00);
    issue(16'h5410, 8'h30, 8'h80, 5'h01);
    issue(16'h0610, 8'h00, 8'h00, 5'h1F);
    issue(16'h0410, 8'h80, 8'h00, 5'h00);
    issue(16'h6C10, 8'h80, 8'h00, 5'h00);
    issue(16'h6D10, 8'h00, 8'h00, 5'h00);
    // R6 directed
    issue(16'h1410, 8'hF0, 8'h0F, 5'h0B);
    issue(16'h1E10, 8'h00, 8'h00, 5'h0B);
    issue(16'h5010, 8'h80, 8'h00, 5'h00);
    // R7 directed
    issue(16'h3610, 8'h80, 8'h00, 5'h00);
    issue(16'h3010, 8'h01, 8'h00, 5'h01);
    issue(16'h4610, 8'h81, 8'h00, 5'h01);
    issue(16'h4010, 8'h01, 8'h00, 5'h00);
    // R8 directed
    issue(16'h3A10, 8'hA5, 8'h00, 5'h15);
    issue(16'h6A10, 8'hA5, 8'h00, 5'h1B);
    issue(16'h6810, 8'h00, 8'h00, 5'h0A);
    issue(16'h6F10, 8'h00, 8'h3C, 5'h1F);
    // R9 directed: compare/skip and other unsupported words
    issue(16'h6010, 8'h00, 8'h00, 5'h15);
    issue(16'hFFFF, 8'h00, 8'h00, 5'h0A);
    issue(16'h0210, 8'h00, 8'h00, 5'h1F);
    idle();
    idle();
    // random stream with occasional idle cycles
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] iw;
      int sel;
      sel = $urandom_range(0, 9);
      iw = $urandom;
      if (sel < 7) iw[15:10] = p6[$urandom_range(0, 16)];
      else if (sel < 9) iw[15:9] = p7[$urandom_range(0, 3)];
      if ($urandom_range(0, 15) == 0) idle();
      else issue(iw, $urandom, $urandom, $urandom);
    end
    idle();
    @(negedge clk);
    checkPending();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule